// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block stores a 256-entry color lookup table, kept as three separate 8-bit arrays for red, green and blue. A processor fills the table through a small register port with two registers. One register selects the palette entry. The other is a colormap data register that accepts bytes and feeds them into a red, green, blue write sequencer. After the blue byte of an entry is stored, the sequencer moves to the next entry by itself. A colormap write can carry one byte or a full 32-bit word. A word is taken apart into four byte steps, starting with the most significant byte, so a single word can complete one entry and begin the next.

On the display side, a pixel lookup port turns an 8-bit pixel index into a 24-bit RGB value one cycle later. Because the palette contents affect the whole visible image, the block keeps a full-refresh request flag. Any colormap write raises it. It is also raised after reset. The display side lowers it with a one-cycle acknowledge once it has started a complete redraw.

Top module: `clut_loader`

## Requirements
- R1: A write with `regSel`=0 (entry-select register) loads `regWData[7:0]` as the current entry and returns the sequencer to the red phase, even when an entry is partly loaded.
- R2: Colormap bytes (`regSel`=1) are stored at the current entry in the order red, green, blue, one phase per byte.
- R3: Storing the blue byte advances the current entry by one modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R4: With `regWord`=0 a colormap write supplies the single byte `regWData[7:0]`. With `regWord`=1 it supplies four bytes in the order bits 31:24, 23:16, 15:8, 7:0, and each byte advances the sequencer.
- R5: A read strobe `regRd` returns zero on `rdData` in the following cycle, whatever the palette holds.
- R6: When `pixReq` is high in a cycle, `pixValid` is high in the next cycle and `pixRgb` holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0 of the addressed entry.
- R7: A lookup issued in the same cycle as a colormap write to the same entry returns the contents from before that write.
- R8: Reset clears every entry of all three arrays to zero, selects entry 0 with the red phase, and raises `refreshReq`.
- R9: Every colormap write raises `refreshReq`. A one-cycle `refreshAck` lowers it, except that a colormap write in the same cycle keeps it raised. Writes to the entry-select register leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regSel | input | 1 | 0 = entry-select register, 1 = colormap data register |
| regWord | input | 1 | 0 = byte access, 1 = 32-bit word access |
| regWData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after `regRd` |
| pixReq | input | 1 | Lookup request |
| pixIdx | input | 8 | Pixel index to translate |
| pixValid | output | 1 | Lookup result valid |
| pixRgb | output | 24 | Looked-up color {R,G,B} |
| refreshAck | input | 1 | Display acknowledges the full redraw |
| refreshReq | output | 1 | Full-screen refresh requested |

## Verification
A sequencer phase that has drifted shows up as a wrong color component at the entry being loaded. A wrong entry counter shows up as colors landing one entry away. Neither is visible until a lookup of the affected entry, which takes one cycle, so the bench reads back every entry it loads, including entries that a word write finished or started. The words are chosen so that phase and index errors change the result, for example partial entries, a wrap from 255 to 0, and a reselect in the middle of an entry. A dropped or late update of the refresh flag shows at `refreshReq` in the cycle right after the write or the acknowledge.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int IDX_W   = 8;
  localparam int CH_W    = 8;
  localparam int LANES   = 4;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int DATA_W  = LANES * CH_W;
  localparam int RGB_W   = 3 * CH_W;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;

  typedef struct packed {
    logic             valid;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [CH_W-1:0]  data;
  } lane_t;

  typedef struct packed {
    lane_t [LANES-1:0] lane;
  } strobe_t;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic              regWord,
  input  logic [DATA_W-1:0] regWData,
  input  logic              refreshAck,
  output strobe_t           strobes,
  output logic              refreshReq
);
  logic             idxWr, cmapWr;
  logic [IDX_W-1:0] idxQ, idxD;
  phase_e           phaseQ, phaseD;
  logic             refreshQ;

  assign idxWr  = regWr && !regSel;
  assign cmapWr = regWr && regSel;

  // Walk the byte lanes through the sequencer, most significant byte first.
  always_comb begin
    phase_e           ph;
    logic [IDX_W-1:0] ix;
    ph = phaseQ;
    ix = idxQ;
    for (int k = 0; k < LANES; k++) begin
      strobes.lane[k].valid = cmapWr && (regWord || k == 0);
      strobes.lane[k].data  = regWord ? regWData[DATA_W-1-CH_W*k -: CH_W] : regWData[CH_W-1:0];
      strobes.lane[k].phase = ph;
      strobes.lane[k].idx   = ix;
      if (strobes.lane[k].valid) begin
        unique case (ph)
          PH_RED:  ph = PH_GRN;
          PH_GRN:  ph = PH_BLU;
          default: begin
            ph = PH_RED;
            ix = ix + IDX_W'(1);
          end
        endcase
      end
    end
    phaseD = ph;
    idxD   = ix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      phaseQ   <= PH_RED;
      refreshQ <= 1'b1;
    end else begin
      if (idxWr) begin
        idxQ   <= regWData[IDX_W-1:0];
        phaseQ <= PH_RED;
      end else if (cmapWr) begin
        idxQ   <= idxD;
        phaseQ <= phaseD;
      end
      if (cmapWr)          refreshQ <= 1'b1;
      else if (refreshAck) refreshQ <= 1'b0;
    end
  end

  assign refreshReq = refreshQ;

  p_select_r1: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (phaseQ == PH_RED) && (idxQ == $past(regWData[IDX_W-1:0])));

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ != 2'd3);

  p_blue_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmapWr && !regWord && phaseQ == PH_BLU) |=> (phaseQ == PH_RED) && (idxQ == $past(idxQ) + IDX_W'(1)));

  p_refresh_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmapWr |=> refreshReq);

  p_refresh_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (refreshAck && !cmapWr) |=> !refreshReq);
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              regRd,
  output logic [DATA_W-1:0] rdData,
  input  logic              pixReq,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic              pixValid,
  output logic [RGB_W-1:0]  pixRgb
);
  logic [CH_W-1:0] redMem [DEPTH];
  logic [CH_W-1:0] grnMem [DEPTH];
  logic [CH_W-1:0] bluMem [DEPTH];
  logic            validQ;
  logic [RGB_W-1:0] rgbQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) begin
        redMem[e] <= '0;
        grnMem[e] <= '0;
        bluMem[e] <= '0;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (strobes.lane[k].valid) begin
          unique case (strobes.lane[k].phase)
            PH_RED:  redMem[strobes.lane[k].idx] <= strobes.lane[k].data;
            PH_GRN:  grnMem[strobes.lane[k].idx] <= strobes.lane[k].data;
            default: bluMem[strobes.lane[k].idx] <= strobes.lane[k].data;
          endcase
        end
      end
    end
  end

  // Lookup reads the arrays as they stood before this edge's writes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      rgbQ   <= '0;
      rdQ    <= '0;
    end else begin
      validQ <= pixReq;
      if (pixReq) rgbQ <= {redMem[pixIdx], grnMem[pixIdx], bluMem[pixIdx]};
      if (regRd)  rdQ  <= '0;
    end
  end

  assign pixValid = validQ;
  assign pixRgb   = rgbQ;
  assign rdData   = rdQ;

  p_lookup_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> pixValid);

  p_no_lookup_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pixReq |=> !pixValid);

  generate
    for (genvar g = 1; g < LANES; g++) begin : g_lane_chk
      p_lane_order_r4: assert property (@(posedge clk) disable iff (!rstN)
        strobes.lane[g].valid |-> strobes.lane[g-1].valid);
    end
  endgenerate
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic        regSel,
  input  logic        regWord,
  input  logic [31:0] regWData,
  output logic [31:0] rdData,
  input  logic        pixReq,
  input  logic [7:0]  pixIdx,
  output logic        pixValid,
  output logic [23:0] pixRgb,
  input  logic        refreshAck,
  output logic        refreshReq
);
  strobe_t strobes;

  clut_seq seq_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWord(regWord),
    .regWData(regWData), .refreshAck(refreshAck), .strobes(strobes),
    .refreshReq(refreshReq)
  );

  clut_store store_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regRd(regRd), .rdData(rdData),
    .pixReq(pixReq), .pixIdx(pixIdx), .pixValid(pixValid), .pixRgb(pixRgb)
  );
endmodule

// File: tb/clut_loader_tb.sv
module clut_loader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, regSel = 1'b0, regWord = 1'b0;
  logic [31:0] regWData = '0;
  logic [31:0] rdData;
  logic        pixReq = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic        pixValid;
  logic [23:0] pixRgb;
  logic        refreshAck = 1'b0;
  logic        refreshReq;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  logic [7:0] mR [256], mG [256], mB [256];
  logic [7:0] mIdx;
  int         mPh;
  logic [23:0] expQ [$];
  string       tagQ [$];

  always #2 clk = ~clk;

  clut_loader dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected lookups as results appear.
  always @(negedge clk) begin
    if (rstN && pixValid) begin
      if (expQ.size() == 0) check("R6 unexpected valid", 32'(pixValid), 32'd0);
      else check(tagQ.pop_front(), 32'(pixRgb), 32'(expQ.pop_front()));
    end
  end

  task automatic modelByte(logic [7:0] b);
    case (mPh)
      0: begin mR[mIdx] = b; mPh = 1; end
      1: begin mG[mIdx] = b; mPh = 2; end
      default: begin mB[mIdx] = b; mPh = 0; mIdx = mIdx + 8'd1; end
    endcase
  endtask

  task automatic selWr(logic [7:0] ix);
    @(negedge clk);
    regWr = 1; regSel = 0; regWord = 0; regWData = {24'hABCDEF, ix};
    mIdx = ix; mPh = 0;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic cmapWr(bit word, logic [31:0] d);
    @(negedge clk);
    regWr = 1; regSel = 1; regWord = word; regWData = d;
    if (word) for (int k = 3; k >= 0; k--) modelByte(d[8*k +: 8]);
    else modelByte(d[7:0]);
    @(negedge clk);
    regWr = 0; regWord = 0;
  endtask

  task automatic lookup(logic [7:0] ix, string tag);
    @(negedge clk);
    pixReq = 1; pixIdx = ix;
    expQ.push_back({mR[ix], mG[ix], mB[ix]});
    tagQ.push_back(tag);
    @(negedge clk);
    pixReq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 256; e++) begin mR[e] = 0; mG[e] = 0; mB[e] = 0; end
    mIdx = 0; mPh = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8: reset state
    check("R8 refresh after reset", 32'(refreshReq), 32'd1);
    check("R8 no valid after reset", 32'(pixValid), 32'd0);
    lookup(8'd0, "R8 entry 0 cleared");
    lookup(8'd7, "R8 entry 7 cleared");
    lookup(8'd255, "R8 entry 255 cleared");

    // R9: acknowledge clears
    @(negedge clk); refreshAck = 1; @(negedge clk); refreshAck = 0;
    check("R9 ack clears", 32'(refreshReq), 32'd0);

    // R8: entry 0 selected, red phase after reset
    cmapWr(0, 32'h0000_0011);
    check("R9 cmap write sets refresh", 32'(refreshReq), 32'd1);
    lookup(8'd0, "R8 reset selects entry 0 red");

    // R1/R2: select, then R,G,B bytes
    selWr(8'd10);
    cmapWr(0, 32'h0000_0012); cmapWr(0, 32'h0000_0034); cmapWr(0, 32'h0000_0056);
    lookup(8'd10, "R2 R,G,B order");
    lookup(8'd11, "R3 next entry untouched");

    // R1: reselect mid-entry restarts at red
    selWr(8'd20);
    cmapWr(0, 32'h0000_0077);
    selWr(8'd30);
    cmapWr(0, 32'h0000_00A1); cmapWr(0, 32'h0000_00A2); cmapWr(0, 32'h0000_00A3);
    lookup(8'd20, "R1 partial entry kept");
    lookup(8'd30, "R1 reselect restarts red");

    // R3/R4: word writes across wrap
    selWr(8'd255);
    cmapWr(1, 32'hAABB_CCDD);
    cmapWr(1, 32'h1122_3344);
    lookup(8'd255, "R4 word MSB first");
    lookup(8'd0, "R3 wrap 255 to 0");
    lookup(8'd1, "R4 word spans entries");

    // R4: byte write uses low byte only
    cmapWr(0, 32'hFFFF_FF5A);
    lookup(8'd1, "R4 byte uses bits 7:0");
    lookup(8'd2, "R4 upper bytes ignored");
    cmapWr(0, 32'h0000_0066);
    lookup(8'd2, "R3 advanced after blue");

    // R7: same-cycle write and lookup
    selWr(8'd40);
    @(negedge clk);
    regWr = 1; regSel = 1; regWord = 1; regWData = 32'hC1C2_C3C4;
    pixReq = 1; pixIdx = 8'd40;
    expQ.push_back({mR[40], mG[40], mB[40]}); tagQ.push_back("R7 old value on collision");
    for (int k = 3; k >= 0; k--) modelByte(regWData[8*k +: 8]);
    @(negedge clk);
    regWr = 0; regWord = 0; pixReq = 0;
    lookup(8'd40, "R7 new value after collision");
    lookup(8'd41, "R4 fourth byte to next red");

    // R9: write beats ack, select write leaves flag
    @(negedge clk);
    regWr = 1; regSel = 1; regWData = 32'h0000_0001; refreshAck = 1;
    modelByte(8'h01);
    @(negedge clk);
    regWr = 0; refreshAck = 0;
    check("R9 write wins over ack", 32'(refreshReq), 32'd1);
    @(negedge clk); refreshAck = 1; @(negedge clk); refreshAck = 0;
    check("R9 ack alone clears", 32'(refreshReq), 32'd0);
    selWr(8'd50);
    check("R9 select write leaves flag", 32'(refreshReq), 32'd0);

    // R5: reads return zero
    @(negedge clk); regRd = 1; regSel = 0; @(negedge clk);
    check("R5 select read zero", rdData, 32'd0);
    regSel = 1; @(negedge clk); regRd = 0;
    check("R5 colormap read zero", rdData, 32'd0);

    // R6: bulk load and back-to-back lookups
    selWr(8'd100);
    for (int w = 0; w < 12; w++) cmapWr(1, {8'(w*4+1), 8'(w*4+2), 8'(w*4+3), 8'(w*4+4)} ^ 32'h5A3C_0F96);
    @(negedge clk);
    for (int e = 100; e < 117; e++) begin
      pixReq = 1; pixIdx = 8'(e);
      expQ.push_back({mR[e], mG[e], mB[e]}); tagQ.push_back("R6 bulk lookup");
      @(negedge clk);
    end
    pixReq = 0;
    @(negedge clk); @(negedge clk);
    check("R6 all lookups returned", expQ.size(), 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule